// File: doc/BRIEF.md
# Three-Channel Match Timer

This block holds several independent up-counters, three by default, each with three compare slots. It runs on a slow timer clock that is separate from the clock of its register port. Each counter has a mode bit. In free-running mode it counts through the whole 32-bit range and wraps. In periodic mode it returns to zero after it reaches the value in compare slot 0. When a counter equals one of its compare values, a sticky status bit is set. Software clears that bit by writing a one to it. The interrupt output is high while any status bit with its enable bit set is pending.

Software never reads a running counter directly. It writes a one to the counter's capture word. The request crosses into the timer clock by a toggle, the counter value is latched there, and an acknowledge toggle comes back. While that round trip is in progress a busy bit reads one. Once busy is clear, the capture word returns a value that is whole and does not change while it is read. Writes to enable, mode and compare words are copied into the timer domain as one snapshot. A single copy is in flight at any time, and a write that arrives during a copy causes one more copy afterwards.

A typical one-shot use: program slot 0 with N-1 for an event after N ticks, enable the slot's interrupt, then set the counter's enable bit.

Top module: `match_timer`

## Requirements
- R1: After reset, every status word, the busy word and every capture word read 0, and `irq` is 0.
- R2: Bit t of the enable word (word 0) runs counter t. While the bit is 0 the counter holds 0, and setting the bit again restarts it from 0. The enable bits of the other counters have no effect on it.
- R3: With mode bit t (word 1) at 0, counter t goes up by one on each timer-clock tick and wraps from 2^32-1 to 0.
- R4: With mode bit t at 1, counter t goes from the value in its slot 0 back to 0. It never exceeds that value, and the slot-0 match repeats every period.
- R5: Status bit m of counter t (word 5+t, bit m) is set when the counter equals compare word 16+4t+m, and it stays set. Writing a 1 to a status bit clears only that bit, so writing 0x7 clears all three.
- R6: With slot 0 holding N-1 and the counter enabled from 0, the slot-0 status and an enabled `irq` appear about N timer ticks after the enable write. The extra delay is a few ticks of synchronizer latency.
- R7: `irq` is the OR over all status bits ANDed with the interrupt-enable bits (word 2+t, bit m). Clearing an enable bit masks a pending status without clearing it. Setting the enable bit again raises `irq`.
- R8: Writing 1 in bit 0 of capture word 8+t sets busy bit t (word 11). When busy clears, reading word 8+t returns the value counter t had when the request arrived in the timer domain.
- R9: A burst of back-to-back writes to enable, mode and compare words takes effect with the last values written, even when the writes come faster than the timer clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register-port clock |
| rst_bus | input | 1 | Synchronous active-high reset, register-port domain |
| clk_tmr | input | 1 | Timer tick clock |
| rst_tmr | input | 1 | Synchronous active-high reset, timer domain |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, registered |
| bus_rvalid | output | 1 | High the cycle after a read access |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The assertions check properties that must hold on every cycle. A disabled counter sits at zero. A match toggle moves only on an equal compare of an enabled counter. A latched capture value changes only together with its acknowledge. A status bit holds unless a match event or a status write occurs. `irq` stays low while no enabled status is pending. A capture request always raises busy. Only one configuration copy is in flight at a time. Other behaviour can only be shown by the bench's scenarios: the periodic bound and the period repeating, the free-running rate, restart from zero, the one-shot tick count after crossing both clocks, selective write-one-to-clear, and the last values of a write burst taking effect.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int REG_ENABLE  = 0;
  localparam int REG_MODE    = 1;
  localparam int REG_IE_BASE = 2;
  localparam int MATCH_BASE  = 16;
  localparam int CMP_STRIDE  = 4;

  function automatic int match_word(input int tmr, input int cmp);
    return MATCH_BASE + tmr * CMP_STRIDE + cmp;
  endfunction
endpackage

// File: rtl/mtmr_sync.sv
module mtmr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic                            periodic,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
  input  logic                            cap_req_tog,
  output logic [NUM_CMP-1:0]              hit_tog,
  output logic [CNT_W-1:0]                cap_val,
  output logic                            cap_ack_tog
);
  logic [CNT_W-1:0] cnt;
  logic             req_s, req_d;

  mtmr_sync #(.W(1)) u_req_sync (.clk(clk), .rst(rst), .d(cap_req_tog), .q(req_s));

  always_ff @(posedge clk) begin
    if (rst || !en)                       cnt <= '0;
    else if (periodic && cnt == cmp_val[0]) cnt <= '0;
    else                                  cnt <= cnt + 1'b1;
  end

  for (genvar m = 0; m < NUM_CMP; m++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)                            hit_tog[m] <= 1'b0;
      else if (en && cnt == cmp_val[m])   hit_tog[m] <= ~hit_tog[m];
    end

    // R5: a match event only follows an equal compare of an enabled counter
    p_hit_equal_r5: assert property (@(posedge clk) disable iff (rst)
      (hit_tog[m] != $past(hit_tog[m])) |-> ($past(en) && $past(cnt) == $past(cmp_val[m])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d       <= 1'b0;
      cap_val     <= '0;
      cap_ack_tog <= 1'b0;
    end else begin
      req_d <= req_s;
      if (req_s != req_d) begin
        cap_val     <= cnt;
        cap_ack_tog <= ~cap_ack_tog;
      end
    end
  end

  // R2: a counter whose enable is low sits at zero
  p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

  // R8: the latched value never moves without an acknowledge
  p_cap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cap_val != $past(cap_val)) |-> (cap_ack_tog != $past(cap_ack_tog)));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 6
) (
  input  logic              clk_bus,
  input  logic              rst_bus,
  input  logic              clk_tmr,
  input  logic              rst_tmr,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  localparam int NCH       = NUM_TMR * NUM_CMP;
  localparam int ST_BASE   = REG_IE_BASE + NUM_TMR;
  localparam int CAP_BASE  = ST_BASE + NUM_TMR;
  localparam int BUSY_WORD = CAP_BASE + NUM_TMR;

  logic                          wr, rd;
  logic [NUM_TMR-1:0]            en_b, mode_b, cap_req, ack_s, busy;
  logic [NUM_TMR-1:0]            en_t, mode_t, ack_all;
  logic [NCH-1:0]                ie_b, st_b, st_clr, hit_all, hit_s, hit_d, hit_evt;
  logic [NCH-1:0][CNT_W-1:0]     match_b, match_t;
  logic [NUM_TMR-1:0][CNT_W-1:0] cap_all;
  logic                          cfg_wr, cfg_pend, cfg_tog, cfg_ack_s, cfg_idle;
  logic                          cfg_s, cfg_d, st_wr;
  logic [CNT_W-1:0]              rd_word;

  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign hit_evt  = hit_s ^ hit_d;
  assign busy     = cap_req ^ ack_s;
  assign cfg_idle = (cfg_tog == cfg_ack_s);

  // ---------------- register-port domain ----------------
  always_comb begin
    cfg_wr = wr && (bus_addr == ADDR_W'(REG_ENABLE) || bus_addr == ADDR_W'(REG_MODE));
    st_clr = '0;
    st_wr  = 1'b0;
    for (int t = 0; t < NUM_TMR; t++) begin
      for (int m = 0; m < NUM_CMP; m++)
        if (wr && bus_addr == ADDR_W'(match_word(t, m))) cfg_wr = 1'b1;
      if (wr && bus_addr == ADDR_W'(ST_BASE + t)) begin
        st_wr = 1'b1;
        st_clr[t*NUM_CMP +: NUM_CMP] = bus_wdata[NUM_CMP-1:0];
      end
    end
  end

  always_ff @(posedge clk_bus) begin
    if (rst_bus) begin
      en_b <= '0; mode_b <= '0; ie_b <= '0; match_b <= '0;
      cap_req <= '0; cfg_tog <= 1'b0; cfg_pend <= 1'b0;
    end else begin
      if (cfg_wr || cfg_pend) begin
        if (cfg_idle) begin
          cfg_tog  <= ~cfg_tog;
          cfg_pend <= 1'b0;
        end else begin
          cfg_pend <= 1'b1;
        end
      end
      if (wr && bus_addr == ADDR_W'(REG_ENABLE)) en_b   <= bus_wdata[NUM_TMR-1:0];
      if (wr && bus_addr == ADDR_W'(REG_MODE))   mode_b <= bus_wdata[NUM_TMR-1:0];
      for (int t = 0; t < NUM_TMR; t++) begin
        if (wr && bus_addr == ADDR_W'(REG_IE_BASE + t))
          ie_b[t*NUM_CMP +: NUM_CMP] <= bus_wdata[NUM_CMP-1:0];
        if (wr && bus_addr == ADDR_W'(CAP_BASE + t) && bus_wdata[0] && !busy[t])
          cap_req[t] <= ~cap_req[t];
        for (int m = 0; m < NUM_CMP; m++)
          if (wr && bus_addr == ADDR_W'(match_word(t, m)))
            match_b[t*NUM_CMP + m] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk_bus) begin
    if (rst_bus) begin
      hit_d <= '0;
      st_b  <= '0;
      irq   <= 1'b0;
    end else begin
      hit_d <= hit_s;
      st_b  <= (st_b & ~st_clr) | hit_evt;
      irq   <= |(st_b & ie_b);
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_W'(REG_ENABLE)) rd_word[NUM_TMR-1:0] = en_b;
    if (bus_addr == ADDR_W'(REG_MODE))   rd_word[NUM_TMR-1:0] = mode_b;
    if (bus_addr == ADDR_W'(BUSY_WORD))  rd_word[NUM_TMR-1:0] = busy;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (bus_addr == ADDR_W'(REG_IE_BASE + t)) rd_word[NUM_CMP-1:0] = ie_b[t*NUM_CMP +: NUM_CMP];
      if (bus_addr == ADDR_W'(ST_BASE + t))     rd_word[NUM_CMP-1:0] = st_b[t*NUM_CMP +: NUM_CMP];
      if (bus_addr == ADDR_W'(CAP_BASE + t))    rd_word = cap_all[t];
      for (int m = 0; m < NUM_CMP; m++)
        if (bus_addr == ADDR_W'(match_word(t, m))) rd_word = match_b[t*NUM_CMP + m];
    end
  end

  always_ff @(posedge clk_bus) begin
    if (rst_bus) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_word;
    end
  end

  mtmr_sync #(.W(NCH))     u_hit_sync (.clk(clk_bus), .rst(rst_bus), .d(hit_all), .q(hit_s));
  mtmr_sync #(.W(NUM_TMR)) u_ack_sync (.clk(clk_bus), .rst(rst_bus), .d(ack_all), .q(ack_s));
  mtmr_sync #(.W(1))       u_cfa_sync (.clk(clk_bus), .rst(rst_bus), .d(cfg_d),   .q(cfg_ack_s));

  // ---------------- timer domain ----------------
  mtmr_sync #(.W(1)) u_cfg_sync (.clk(clk_tmr), .rst(rst_tmr), .d(cfg_tog), .q(cfg_s));

  always_ff @(posedge clk_tmr) begin
    if (rst_tmr) begin
      cfg_d   <= 1'b0;
      en_t    <= '0;
      mode_t  <= '0;
      match_t <= '0;
    end else begin
      cfg_d <= cfg_s;
      if (cfg_s != cfg_d) begin
        en_t    <= en_b;
        mode_t  <= mode_b;
        match_t <= match_b;
      end
    end
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
    mtmr_channel #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_ch (
      .clk        (clk_tmr),
      .rst        (rst_tmr),
      .en         (en_t[g]),
      .periodic   (mode_t[g]),
      .cmp_val    (match_t[g*NUM_CMP +: NUM_CMP]),
      .cap_req_tog(cap_req[g]),
      .hit_tog    (hit_all[g*NUM_CMP +: NUM_CMP]),
      .cap_val    (cap_all[g]),
      .cap_ack_tog(ack_all[g])
    );

    // R8: an accepted capture request makes the counter's busy bit read one
    p_busy_on_req_r8: assert property (@(posedge clk_bus) disable iff (rst_bus)
      (wr && bus_addr == ADDR_W'(CAP_BASE + g) && bus_wdata[0] && !busy[g]) |=> busy[g]);
  end

  // R5: status is sticky unless a match event or a status write occurs
  p_status_hold_r5: assert property (@(posedge clk_bus) disable iff (rst_bus)
    (hit_evt == '0 && !st_wr) |=> $stable(st_b));

  // R7: no enabled pending status means no interrupt
  p_irq_mask_r7: assert property (@(posedge clk_bus) disable iff (rst_bus)
    ((st_b & ie_b) == '0) |=> !irq);

  // R9: a new snapshot is launched only after the previous one was taken
  p_cfg_one_flight_r9: assert property (@(posedge clk_bus) disable iff (rst_bus)
    (cfg_tog != $past(cfg_tog)) |-> ($past(cfg_tog) == $past(cfg_ack_s)));
endmodule

// File: tb/tb_match_timer.sv
`timescale 1ns/1ps
module tb_match_timer;
  localparam int EN_W = 0, MODE_W = 1, IE_W = 2, ST_W = 5, CAP_W = 8, BUSY_W = 11;

  typedef struct {
    string       tag;
    logic [31:0] lo;
    logic [31:0] hi;
  } exp_t;

  logic        clk_bus = 1'b0, clk_tmr = 1'b0;
  logic        rst_bus = 1'b1, rst_tmr = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;

  int          tests = 0, fails = 0;
  logic [31:0] last_rd = '0;
  bit          done = 1'b0;
  exp_t        sb_q[$];

  always #2.5 clk_bus = ~clk_bus;
  initial begin
    #1.3;
    forever #20 clk_tmr = ~clk_tmr;
  end

  match_timer dut (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_tmr(clk_tmr), .rst_tmr(rst_tmr),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  function automatic int mw(input int t, input int m);
    return 16 + 4 * t + m;
  endfunction

  // monitor: pops the scoreboard as read data comes back
  always @(negedge clk_bus) begin
    exp_t e;
    if (!rst_bus && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard (R8): actual read %0h expected no read", bus_rdata);
      end else begin
        e = sb_q.pop_front();
        tests++;
        last_rd = bus_rdata;
        if (bus_rdata < e.lo || bus_rdata > e.hi) begin
          fails++;
          $display("FAIL %s: actual %0d expected %0d..%0d", e.tag, bus_rdata, e.lo, e.hi);
        end
      end
    end
  end

  task automatic bwrite(input int a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk_bus);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bread(input int a, input logic [31:0] lo, input logic [31:0] hi, input string tag);
    exp_t e;
    e.tag = tag; e.lo = lo; e.hi = hi;
    sb_q.push_back(e);
    @(negedge clk_bus);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 6'(a);
    @(negedge clk_bus);
    bus_valid = 1'b0;
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk_bus);
  endtask

  task automatic wait_tmr(input int n);
    repeat (n) @(posedge clk_tmr);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic capture(input int t, input logic [31:0] lo, input logic [31:0] hi, input string tag);
    bwrite(CAP_W + t, 32'd1);
    bread(BUSY_W, 32'(1 << t), 32'(1 << t), "R8 busy set after capture request");
    wait_tmr(12);
    bread(BUSY_W, 0, 0, "R8 busy clears after handshake");
    bread(CAP_W + t, lo, hi, tag);
  endtask

  initial begin
    int a;
    int n;
    repeat (30) @(negedge clk_bus);
    rst_bus = 1'b0; rst_tmr = 1'b0;
    @(negedge clk_bus);

    chk("R1 irq after reset", {31'd0, irq}, 0);
    for (int t = 0; t < 3; t++) bread(ST_W + t, 0, 0, "R1 status after reset");
    bread(BUSY_W, 0, 0, "R1 busy after reset");
    bread(CAP_W, 0, 0, "R1 capture after reset");

    // periodic counter 0, configured by a back-to-back burst
    bwrite(mw(0, 1), 1000);
    bwrite(mw(0, 2), 2000);
    bwrite(mw(0, 0), 40);
    bwrite(MODE_W, 1);
    bwrite(EN_W, 1);
    wait_tmr(60);
    capture(0, 0, 40, "R4/R9 periodic count bounded by slot 0");
    bwrite(EN_W, 0);
    wait_tmr(12);
    bread(ST_W, 1, 1, "R5 slot 0 status set on match");
    bwrite(ST_W, 1);
    bread(ST_W, 0, 0, "R5 write one clears status");
    capture(0, 0, 0, "R2 disabled counter held at zero");
    bwrite(EN_W, 1);
    wait_tmr(100);
    bread(ST_W, 1, 1, "R4 periodic match recurs");
    bwrite(EN_W, 0);
    wait_tmr(10);
    bwrite(ST_W, 7);
    bread(ST_W, 0, 0, "R5 write 0x7 clears all");

    // free-running counter 1
    for (int m = 0; m < 3; m++) bwrite(mw(1, m), 32'hFFFF_0000);
    bwrite(EN_W, 2);
    wait_tmr(30);
    capture(1, 22, 38, "R3 free-running count after 30 ticks");
    drain();
    a = int'(last_rd);
    wait_tmr(50);
    capture(1, 32'(a + 55), 32'(a + 75), "R3 free-running count advances per tick");
    capture(0, 0, 0, "R2 other counter with clear enable bit stays zero");
    bwrite(EN_W, 0);
    wait_tmr(12);
    capture(1, 0, 0, "R2 cleared enable resets counter");
    bwrite(EN_W, 2);
    wait_tmr(20);
    capture(1, 14, 26, "R2 re-enabled counter restarts from zero");
    drain();

    // one-shot on counter 2: N = 16 so slot 0 holds 15
    bwrite(mw(2, 0), 15);
    bwrite(mw(2, 1), 15);
    bwrite(mw(2, 2), 32'hFFFF_FF00);
    bwrite(IE_W + 2, 1);
    wait_tmr(12);
    chk("R7 no irq before match", {31'd0, irq}, 0);
    bwrite(EN_W, 4);
    n = 0;
    while (!irq && n < 200) begin
      @(posedge clk_tmr);
      n++;
    end
    tests++;
    if (n < 16 || n > 24) begin
      fails++;
      $display("FAIL R6 one-shot delay: actual %0d ticks expected 16..24", n);
    end
    bread(ST_W + 2, 3, 3, "R5 both equal slots set");
    bwrite(ST_W + 2, 2);
    bread(ST_W + 2, 1, 1, "R5 write one clears only that bit");
    chk("R7 irq kept by enabled slot 0", {31'd0, irq}, 1);
    bwrite(IE_W + 2, 0);
    repeat (2) @(negedge clk_bus);
    chk("R7 masked status drops irq", {31'd0, irq}, 0);
    bread(ST_W + 2, 1, 1, "R7 masked status stays pending");
    bwrite(IE_W + 2, 1);
    repeat (2) @(negedge clk_bus);
    chk("R7 unmask raises irq", {31'd0, irq}, 1);
    bwrite(ST_W + 2, 1);
    repeat (2) @(negedge clk_bus);
    chk("R5 clearing last status drops irq", {31'd0, irq}, 0);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #900_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule